// File: doc/BRIEF.md
# Dual-Width Instruction Prefetch Queue

This block keeps two instruction slots filled in front of a processor core that can execute either full 32-bit instructions or 16-bit compressed ones. Its code memory port always returns 32-bit words. On a branch it decides which instruction width applies, aligns the target and refills both slots. After that it presents the current instruction, its program counter value and the active width to the core. On each issue it shifts the queue and refills the vacated slot.

In compressed mode one fetched word holds two instructions. The queue therefore reads memory only when the program counter crosses onto a new word. In every other case it reuses the upper halfword it already holds. Fetches use a request handshake with a separate response strobe, and the block stalls issue until every word a refill needs has returned. A branch may also take its width from a saved status flag rather than from bit 0 of the target.

The controller is a state machine with eight states:
- IDLE: empty after reset.
- RUN: both slots valid, issue allowed.
- BR0_REQ and BR0_WAIT: first word of a branch refill.
- BR1_REQ and BR1_WAIT: second word of a branch refill.
- SEQ_REQ and SEQ_WAIT: sequential refill after an issue.

Transitions:
- IDLE or RUN go to BR0_REQ on a branch.
- RUN goes to SEQ_REQ on an issue that needs a fetch, and stays in RUN on an issue that does not.
- Each REQ state goes to its WAIT state when the request is accepted.
- BR0_WAIT goes to RUN for a compressed, word-aligned target, and to BR1_REQ for any other target.
- BR1_WAIT and SEQ_WAIT go to RUN when the response arrives.

Top module: `pq_prefetch`

## Requirements
- R1: After reset `q_ready_o` is 0, `fetch_valid_o` is 0, `pc_o` is 0 and `half_mode_o` is 0.
- R2: A branch whose effective bit 0 is 0 selects full mode and clears the low two target bits. It fetches the word at the target and then the word at target+4, sets `pc_o` to target+4, and then shows the word at the target as the current instruction. Every fetch address is word aligned (bits 1:0 are 0).
- R3: A branch whose effective bit 0 is 1 and whose bit 1 is 0 selects compressed mode with a single fetch at the target. `pc_o` becomes target+2 (bit 0 cleared), and the current instruction is the low halfword of that word.
- R4: A compressed branch with target bit 1 set fetches the word at target-2 and then the word at target+2. `pc_o` becomes target+2, and the current instruction is the upper halfword of the first word.
- R5: When `br_restore_i` is 1, `saved_half_i` replaces bit 0 of the target in choosing the mode and the alignment.
- R6: In full mode an accepted issue adds 4 to `pc_o` and moves the next word into the current slot. It fetches the word at the new `pc_o`, and `q_ready_o` stays 0 until that word returns.
- R7: In compressed mode an issue that moves `pc_o` onto an address with bit 1 set makes no fetch, and `q_ready_o` stays 1.
- R8: In compressed mode an issue that moves `pc_o` onto a word-aligned address fetches that word and drops `q_ready_o` until it returns. `pc_o` grows by 2 per issue.
- R9: In compressed mode the upper 16 bits of `instr_o` are 0, and the low 16 bits carry the instruction.
- R10: A fetch request holds its address until it is accepted. An issue request while `q_ready_o` is 0 has no effect on `pc_o` or on the instruction stream.
- R11: A branch and an issue presented together in RUN take the branch, and the issue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid_i | input | 1 | Branch request, taken in IDLE or RUN |
| br_addr_i | input | AW | Branch target; bit 0 selects the width |
| br_restore_i | input | 1 | Take the mode from `saved_half_i` |
| saved_half_i | input | 1 | Saved mode flag, 1 = compressed |
| issue_i | input | 1 | Consume the current instruction |
| fetch_valid_o | output | 1 | Fetch request valid |
| fetch_addr_o | output | AW | Word-aligned fetch address |
| fetch_ready_i | input | 1 | Memory accepts the request |
| fetch_rvalid_i | input | 1 | Response word valid |
| fetch_rdata_i | input | 2*HW | Response word |
| instr_o | output | 2*HW | Current instruction |
| pc_o | output | AW | Program counter (address of current instruction plus one step) |
| half_mode_o | output | 1 | 1 = compressed mode |
| q_ready_o | output | 1 | Queue full, issue allowed |

## Verification
A branch or an issue is applied at one clock edge. `pc_o` and `half_mode_o` reflect it at the next falling edge, and the bench compares them there with its own model of the program counter. The current instruction is compared only at falling edges where `q_ready_o` is 1. At those points the expected value is computed from the memory's address-derived contents, so any latency of the randomly stalling memory is absorbed.

The outcome of an issue on `q_ready_o` is checked at the first falling edge after the issue edge. At that point a fetch can not yet have completed, so `q_ready_o` must be 0 in full mode and on word-aligned compressed advances, and must still be 1 on the other compressed advances. The number of fetches each directed branch makes, and their addresses, are read from the bench's memory responder once the queue reports ready.

// File: rtl/pq_pkg.sv
package pq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_BR0_REQ,
        ST_BR0_WAIT,
        ST_BR1_REQ,
        ST_BR1_WAIT,
        ST_SEQ_REQ,
        ST_SEQ_WAIT
    } pq_state_e;

    typedef enum logic [1:0] {
        BK_FULL,
        BK_HALF_LO,
        BK_HALF_HI
    } br_kind_e;

    typedef enum logic [2:0] {
        Q_HOLD,
        Q_SHIFT,
        Q_LOAD0,
        Q_LOAD0_HI,
        Q_LOAD0_SPLIT,
        Q_LOAD1
    } q_op_e;

endpackage

// File: rtl/pq_branch_decode.sv
module pq_branch_decode
    import pq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  logic          restore_i,
    input  logic          saved_half_i,
    output logic          half_o,
    output br_kind_e      kind_o,
    output logic [AW-1:0] first_addr_o,
    output logic [AW-1:0] pc_o
);
    logic          eff_half;
    logic [AW-1:0] aligned;

    always_comb begin
        eff_half = restore_i ? saved_half_i : addr_i[0];
        half_o   = eff_half;
        if (eff_half) begin
            aligned = {addr_i[AW-1:1], 1'b0};
            pc_o    = aligned + AW'(2);
            kind_o  = aligned[1] ? BK_HALF_HI : BK_HALF_LO;
        end else begin
            aligned = {addr_i[AW-1:2], 2'b00};
            pc_o    = aligned + AW'(4);
            kind_o  = BK_FULL;
        end
        first_addr_o = {aligned[AW-1:2], 2'b00};
    end
endmodule

// File: rtl/pq_advance.sv
module pq_advance #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] pc_i,
    input  logic          half_i,
    output logic [AW-1:0] next_pc_o,
    output logic [AW-1:0] next_word_o,
    output logic          need_fetch_o
);
    always_comb begin
        next_pc_o    = pc_i + (half_i ? AW'(2) : AW'(4));
        next_word_o  = {next_pc_o[AW-1:2], 2'b00};
        need_fetch_o = !half_i || !next_pc_o[1];
    end
endmodule

// File: rtl/pq_slot_queue.sv
module pq_slot_queue
    import pq_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  q_op_e         op_i,
    input  logic [2*HW-1:0] data_i,
    output logic [2*HW-1:0] slot0_o,
    output logic [2*HW-1:0] slot1_o
);
    localparam int WW = 2 * HW;

    logic [WW-1:0] s0_q, s1_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0_q <= '0;
            s1_q <= '0;
        end else begin
            unique case (op_i)
                Q_HOLD: ;
                Q_SHIFT: begin
                    s0_q <= s1_q;
                    s1_q <= s1_q >> HW;
                end
                Q_LOAD0:    s0_q <= data_i;
                Q_LOAD0_HI: s0_q <= data_i >> HW;
                Q_LOAD0_SPLIT: begin
                    s0_q <= data_i;
                    s1_q <= data_i >> HW;
                end
                Q_LOAD1:    s1_q <= data_i;
                default: ;
            endcase
        end
    end

    assign slot0_o = s0_q;
    assign slot1_o = s1_q;
endmodule

// File: rtl/pq_prefetch.sv
module pq_prefetch
    import pq_pkg::*;
#(
    parameter int AW = 32,
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            br_valid_i,
    input  logic [AW-1:0]   br_addr_i,
    input  logic            br_restore_i,
    input  logic            saved_half_i,
    input  logic            issue_i,
    output logic            fetch_valid_o,
    output logic [AW-1:0]   fetch_addr_o,
    input  logic            fetch_ready_i,
    input  logic            fetch_rvalid_i,
    input  logic [2*HW-1:0] fetch_rdata_i,
    output logic [2*HW-1:0] instr_o,
    output logic [AW-1:0]   pc_o,
    output logic            half_mode_o,
    output logic            q_ready_o
);
    localparam int WW = 2 * HW;

    pq_state_e     state_q, state_d;
    br_kind_e      kind_q;
    logic [AW-1:0] pc_q, faddr_q;
    logic          half_q;

    q_op_e         q_op;
    logic          take_br, take_issue, br0_done;
    logic [WW-1:0] slot0, slot1;

    logic          dec_half;
    br_kind_e      dec_kind;
    logic [AW-1:0] dec_first, dec_pc;
    logic [AW-1:0] adv_pc, adv_word;
    logic          adv_fetch;

    pq_branch_decode #(.AW(AW)) u_dec (
        .addr_i       (br_addr_i),
        .restore_i    (br_restore_i),
        .saved_half_i (saved_half_i),
        .half_o       (dec_half),
        .kind_o       (dec_kind),
        .first_addr_o (dec_first),
        .pc_o         (dec_pc)
    );

    pq_advance #(.AW(AW)) u_adv (
        .pc_i         (pc_q),
        .half_i       (half_q),
        .next_pc_o    (adv_pc),
        .next_word_o  (adv_word),
        .need_fetch_o (adv_fetch)
    );

    pq_slot_queue #(.HW(HW)) u_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (q_op),
        .data_i  (fetch_rdata_i),
        .slot0_o (slot0),
        .slot1_o (slot1)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and queue control
    always_comb begin
        state_d    = state_q;
        q_op       = Q_HOLD;
        take_br    = 1'b0;
        take_issue = 1'b0;
        br0_done   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_RUN: begin
                if (br_valid_i) begin
                    take_br = 1'b1;
                    state_d = ST_BR0_REQ;
                end else if (state_q == ST_RUN && issue_i) begin
                    take_issue = 1'b1;
                    q_op       = Q_SHIFT;
                    state_d    = adv_fetch ? ST_SEQ_REQ : ST_RUN;
                end
            end
            ST_BR0_REQ:  if (fetch_ready_i) state_d = ST_BR0_WAIT;
            ST_BR0_WAIT: begin
                if (fetch_rvalid_i) begin
                    br0_done = 1'b1;
                    unique case (kind_q)
                        BK_HALF_LO: begin
                            q_op    = Q_LOAD0_SPLIT;
                            state_d = ST_RUN;
                        end
                        BK_HALF_HI: begin
                            q_op    = Q_LOAD0_HI;
                            state_d = ST_BR1_REQ;
                        end
                        default: begin
                            q_op    = Q_LOAD0;
                            state_d = ST_BR1_REQ;
                        end
                    endcase
                end
            end
            ST_BR1_REQ:  if (fetch_ready_i) state_d = ST_BR1_WAIT;
            ST_BR1_WAIT: begin
                if (fetch_rvalid_i) begin
                    q_op    = Q_LOAD1;
                    state_d = ST_RUN;
                end
            end
            ST_SEQ_REQ:  if (fetch_ready_i) state_d = ST_SEQ_WAIT;
            ST_SEQ_WAIT: begin
                if (fetch_rvalid_i) begin
                    q_op    = Q_LOAD1;
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // program counter, mode and fetch address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            half_q  <= 1'b0;
            kind_q  <= BK_FULL;
            faddr_q <= '0;
        end else if (take_br) begin
            pc_q    <= dec_pc;
            half_q  <= dec_half;
            kind_q  <= dec_kind;
            faddr_q <= dec_first;
        end else if (take_issue) begin
            pc_q    <= adv_pc;
            faddr_q <= adv_word;
        end else if (br0_done) begin
            faddr_q <= faddr_q + AW'(4);
        end
    end

    // outputs
    always_comb begin
        fetch_valid_o = (state_q == ST_BR0_REQ) || (state_q == ST_BR1_REQ) ||
                        (state_q == ST_SEQ_REQ);
        fetch_addr_o  = faddr_q;
        q_ready_o     = (state_q == ST_RUN);
        pc_o          = pc_q;
        half_mode_o   = half_q;
        instr_o       = half_q ? {{HW{1'b0}}, slot0[HW-1:0]} : slot0;
    end
endmodule

// File: rtl/pq_prefetch_chk.sv
module pq_prefetch_chk #(
    parameter int AW = 32,
    parameter int HW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          br_valid_i,
    input logic [AW-1:0] br_addr_i,
    input logic          br_restore_i,
    input logic          saved_half_i,
    input logic          issue_i,
    input logic          fetch_valid_o,
    input logic [AW-1:0] fetch_addr_o,
    input logic          fetch_ready_i,
    input logic [AW-1:0] pc_o,
    input logic          half_mode_o,
    input logic          q_ready_o
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_o && !fetch_ready_i |=> fetch_valid_o && $stable(fetch_addr_o)); // R10

    AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_o |-> fetch_addr_o[1:0] == 2'b00); // R2

    AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        q_ready_o && issue_i && !br_valid_i && !half_mode_o
        |=> !q_ready_o && pc_o == $past(pc_o) + AW'(4)); // R6

    AST_HALF_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        q_ready_o && issue_i && !br_valid_i && half_mode_o && !pc_o[1]
        |=> q_ready_o && pc_o == $past(pc_o) + AW'(2)); // R7

    AST_BR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        q_ready_o && br_valid_i |=> !q_ready_o); // R11

    AST_RESTORE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        q_ready_o && br_valid_i && br_restore_i |=> half_mode_o == $past(saved_half_i)); // R5

    AST_PLAIN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        q_ready_o && br_valid_i && !br_restore_i |=> half_mode_o == $past(br_addr_i[0])); // R3
endmodule

bind pq_prefetch pq_prefetch_chk #(.AW(AW), .HW(HW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .br_valid_i    (br_valid_i),
    .br_addr_i     (br_addr_i),
    .br_restore_i  (br_restore_i),
    .saved_half_i  (saved_half_i),
    .issue_i       (issue_i),
    .fetch_valid_o (fetch_valid_o),
    .fetch_addr_o  (fetch_addr_o),
    .fetch_ready_i (fetch_ready_i),
    .pc_o          (pc_o),
    .half_mode_o   (half_mode_o),
    .q_ready_o     (q_ready_o)
);

// File: tb/pq_prefetch_bench.sv
module pq_prefetch_bench;
    localparam int AW = 32;
    localparam int HW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          br_valid = 1'b0, br_restore = 1'b0, saved_half = 1'b0, issue = 1'b0;
    logic [31:0]   br_addr = '0;
    logic          fetch_valid, fetch_ready, fetch_rvalid;
    logic [31:0]   fetch_addr, fetch_rdata, instr, pc;
    logic          half_mode, q_ready;

    always #10 clk = ~clk;

    pq_prefetch #(.AW(AW), .HW(HW)) u_pq_prefetch (
        .clk(clk), .rst_n(rst_n), .br_valid_i(br_valid), .br_addr_i(br_addr),
        .br_restore_i(br_restore), .saved_half_i(saved_half), .issue_i(issue),
        .fetch_valid_o(fetch_valid), .fetch_addr_o(fetch_addr),
        .fetch_ready_i(fetch_ready), .fetch_rvalid_i(fetch_rvalid),
        .fetch_rdata_i(fetch_rdata), .instr_o(instr), .pc_o(pc),
        .half_mode_o(half_mode), .q_ready_o(q_ready)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'h9C00, a[15:0] + 16'h0100};
    endfunction

    function automatic logic [31:0] exp_instr(input logic [31:0] a, input bit h);
        logic [31:0] w;
        w = mem_word({a[31:2], 2'b00});
        if (!h) return w;
        return a[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
    endfunction

    // memory responder with random acceptance and latency
    logic        pend;
    logic [1:0]  lat;
    logic [31:0] paddr, fa_last, fa_prev;
    int          nfetch;
    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0; lat <= '0; paddr <= '0; fetch_ready <= 1'b0;
            fetch_rvalid <= 1'b0; fetch_rdata <= '0; nfetch <= 0;
            fa_last <= '0; fa_prev <= '0;
        end else begin
            fetch_rvalid <= 1'b0;
            if (fetch_valid && fetch_ready) begin
                pend <= 1'b1; paddr <= fetch_addr; lat <= 2'($urandom % 3);
                nfetch <= nfetch + 1; fa_prev <= fa_last; fa_last <= fetch_addr;
                fetch_ready <= 1'b0;
            end else if (pend) begin
                fetch_ready <= 1'b0;
                if (lat == 0) begin
                    fetch_rvalid <= 1'b1; fetch_rdata <= mem_word(paddr); pend <= 1'b0;
                end else lat <= lat - 2'd1;
            end else begin
                fetch_ready <= ($urandom % 4) != 0;
            end
        end
    end

    int n_tests = 0, n_fail = 0;
    logic [31:0] pc_m = '0;
    bit half_m = 0, live_m = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, observe at next falling edge
    task automatic step(input bit br, input logic [31:0] a, input bit rs, input bit sv, input bit is);
        bit rdy, eff, acc_is;
        rdy = q_ready;
        br_valid = br; br_addr = a; br_restore = rs; saved_half = sv; issue = is;
        @(posedge clk);
        @(negedge clk);
        br_valid = 0; issue = 0; br_restore = 0;
        acc_is = 0;
        if (br && (rdy || !live_m)) begin
            eff = rs ? sv : a[0];
            half_m = eff; live_m = 1;
            pc_m = eff ? ({a[31:1], 1'b0} + 32'd2) : ({a[31:2], 2'b00} + 32'd4);
        end else if (is && rdy) begin
            pc_m = pc_m + (half_m ? 32'd2 : 32'd4);
            acc_is = 1;
        end
        if (live_m) begin
            chk(pc == pc_m, "R10 pc", pc, pc_m);
            chk(half_mode == half_m, "R5 mode", {31'h0, half_mode}, {31'h0, half_m});
        end
        if (acc_is) begin
            if (!half_m) chk(q_ready == 1'b0, "R6 stall", {31'h0, q_ready}, 32'h0);
            else if (pc_m[1]) chk(q_ready == 1'b1, "R7 no fetch", {31'h0, q_ready}, 32'h1);
            else chk(q_ready == 1'b0, "R8 fetch", {31'h0, q_ready}, 32'h0);
        end
        if (q_ready && live_m) begin
            chk(instr == exp_instr(pc_m - (half_m ? 32'd2 : 32'd4), half_m), "R9 instr",
                instr, exp_instr(pc_m - (half_m ? 32'd2 : 32'd4), half_m));
        end
    endtask

    task automatic wait_ready(input bit poke);
        for (int i = 0; i < 50 && !q_ready; i++) step(0, '0, 0, 0, poke);
    endtask

    task automatic dir_branch(input logic [31:0] a, input bit rs, input bit sv, input string req,
                              input int nexp, input logic [31:0] f0, input logic [31:0] f1);
        int n0;
        n0 = nfetch;
        step(1, a, rs, sv, 0);
        wait_ready(0);
        chk(nfetch - n0 == nexp, req, nfetch - n0, nexp);
        if (nexp == 2) begin
            chk(fa_prev == f0, req, fa_prev, f0);
            chk(fa_last == f1, req, fa_last, f1);
        end else chk(fa_last == f0, req, fa_last, f0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(q_ready == 0 && fetch_valid == 0, "R1 flags", {30'h0, q_ready, fetch_valid}, 32'h0);
        chk(pc == 0 && half_mode == 0, "R1 pc", pc, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        dir_branch(32'h0000_0102, 0, 0, "R2 full", 2, 32'h100, 32'h104);
        dir_branch(32'h0000_0201, 0, 0, "R3 half aligned", 1, 32'h200, 32'h0);
        dir_branch(32'h0000_0303, 0, 0, "R4 half upper", 2, 32'h300, 32'h304);
        dir_branch(32'h0000_0400, 1, 1, "R5 restore half", 1, 32'h400, 32'h0);
        dir_branch(32'h0000_0507, 1, 0, "R5 restore full", 2, 32'h504, 32'h508);
        // full issue stream
        for (int i = 0; i < 4; i++) begin step(0, '0, 0, 0, 1); wait_ready(1); end // R6, R10
        // compressed stream from a word-aligned target
        dir_branch(32'h0000_0601, 0, 0, "R8 setup", 1, 32'h600, 32'h0);
        for (int i = 0; i < 6; i++) begin step(0, '0, 0, 0, 1); wait_ready(1); end // R7, R8, R9
        // R11: branch and issue together
        step(1, 32'h0000_0700, 0, 0, 1);
        chk(q_ready == 0 && pc == 32'h704, "R11 branch wins", pc, 32'h704);
        wait_ready(1);

        for (int i = 0; i < 3000; i++) begin
            if ((q_ready || !live_m) && ($urandom % 16) == 0)
                step(1, {20'h0, 12'($urandom)}, ($urandom % 4) == 0, 1'($urandom), 1'($urandom));
            else
                step(0, '0, 0, 0, 1'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule